// File: doc/BRIEF.md
# I2C Slave Transmitter Status Engine

This block is the transmit half of an I2C target. It watches the SCL and SDA lines through a synchronizer, recognizes START and STOP, and collects the address frame. When the address matches its own 7-bit address and the direction bit asks for a read, it acknowledges. It then shifts bytes that the host has written out onto SDA and samples the master's acknowledge after each one. Every step that needs the host raises the SI flag and shows a status byte. While SI is set, SCL is held low, so the master waits until the host has answered and cleared SI.

An acknowledge-enable input gates address recognition. The engine latches it each time the host clears SI to release the next byte. If it is low at that point, the byte still goes out, the engine reports that the last byte has left, and it then detaches. Any further read clocks from the master return all ones until a new START addresses the engine again. A pulse on the arbitration-lost input marks that this device has just dropped out of a master transfer. The next successful read addressing then reports a separate status code.

The outputs are pull-down enables for the two open-drain lines. The line inputs are the resolved bus levels.

Top module: `i2c_slave_tx`

## Requirements
- R1: During and after reset, `si_o` is 0, `status_o` is 8'hF8, and both `sda_low_o` and `scl_hold_o` are 0. Whenever `si_o` is 0, `status_o` reads 8'hF8.
- R2: After a START, a 7-bit address equal to `own_addr_i`, sent MSB first and followed by a direction bit of 1, is acknowledged when `aa_i` is 1. The engine pulls SDA low during the ninth clock. After the ninth clock falls, `si_o` goes to 1 and `status_o` reads 8'hA8.
- R3: While `si_o` is 1, `scl_hold_o` is 1 and `status_o` is stable. A one-cycle pulse on `si_clr_i` clears SI, returns the status to 8'hF8 and releases SCL.
- R4: Clearing SI during a transfer loads `tx_data_i`. The byte is sent MSB first, and SDA changes only while SCL is low. SDA is released during the master's acknowledge clock.
- R5: After a byte, a master ACK (SDA low on the ninth clock) with the latched enable at 1 gives status 8'hB8. A master NACK (SDA high) gives 8'hC0. After a NACK and the clearing of SI, the engine is not addressed, and further read clocks return 8'hFF with no SI.
- R6: If `aa_i` is 0 when SI is cleared to release a byte, that byte is still sent. On a master ACK the status is 8'hC8, and a NACK still gives 8'hC0. Once SI is cleared, the engine is not addressed: later bytes read as 8'hFF and SI stays 0, even if `aa_i` is set again before the next START.
- R7: While `aa_i` is 0, a matching read address is not acknowledged and SI stays 0. Setting `aa_i` to 1 restores recognition from the next START.
- R8: An address that differs from `own_addr_i`, or a matching address with direction bit 0, is not acknowledged and does not set SI.
- R9: After a pulse on `arb_lost_i`, the next acknowledged read address reports 8'hB0 instead of 8'hA8.
- R10: A STOP in the middle of a byte returns the engine to the not-addressed state. SDA is released, and later read clocks without a new START return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_hold_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Own 7-bit target address |
| aa_i | input | 1 | Acknowledge enable from the host |
| tx_data_i | input | 8 | Next byte to send, sampled when SI is cleared |
| si_clr_i | input | 1 | One-cycle pulse that clears SI |
| arb_lost_i | input | 1 | Pulse: this device lost arbitration as a master |
| si_o | output | 1 | Serial event flag |
| status_o | output | 8 | Status code, 8'hF8 when SI is 0 |

## Verification
The bench first goes after the detach path. It drops the enable as a byte is released, then keeps clocking reads. A design that kept driving data, or that reattached when the enable came back without a new START, would return real bits instead of 8'hFF or would raise SI. It sets up both the case where a NACK and a dropped enable coincide and the case where the ACK carries the last-byte flag. A wrong priority would show 8'hC8 where 8'hC0 belongs, or 8'hB8 where 8'hC8 belongs. The bench also sends write-direction and mismatched addresses, a STOP inside a byte, and an address that follows lost arbitration. A loose address compare, a stuck transfer state or a missing arbitration flag would show up as a stray acknowledge, a hung SCL or status 8'hA8.

// File: rtl/i2c_st_pkg.sv
// Package: shared state type and status codes for the slave transmitter engine.
// Assumes: 8-bit status bytes; codes are fixed by the host software contract.
package i2c_st_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, monitoring the bus
        ST_ADDR,   // shifting in the address frame
        ST_AACK,   // driving the address acknowledge
        ST_SEND,   // shifting a data byte out
        ST_MACK,   // listening to the master acknowledge
        ST_HOLD    // SI set, SCL stretched, waiting for the host
    } st_state_e;

    localparam logic [7:0] CODE_NONE      = 8'hF8;
    localparam logic [7:0] CODE_SLA_R     = 8'hA8;
    localparam logic [7:0] CODE_ARB_SLA_R = 8'hB0;
    localparam logic [7:0] CODE_TX_ACK    = 8'hB8;
    localparam logic [7:0] CODE_TX_NACK   = 8'hC0;
    localparam logic [7:0] CODE_LAST_ACK  = 8'hC8;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain and flags SCL edges, START and STOP.
// Assumes: STAGES >= 2; line levels hold for several clocks between changes.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    // Synchronizer chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Edge and bus condition decode from the synchronized levels.
    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_st_core.sv
// Module: i2c_st_core
// Address match, byte shifter, acknowledge sampling and status/SI reporting for
// the slave transmitter. Assumes edge strobes from i2c_line_sync and an address
// frame of DATA_W bits (address MSB first, direction bit last).
module i2c_st_core
    import i2c_st_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              aa,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              si_clr,
    input  logic              arb_lost,
    output logic              si,
    output logic [7:0]        status,
    output logic              sda_low,
    output logic              scl_hold
);

    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    st_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              sda_low_q, si_q, last_q, end_q, arb_q, ack_q;
    logic [7:0]        status_q;
    logic              addr_hit;

    // Own read address seen in the shifted frame and recognition enabled.
    assign addr_hit = (sh_q[DATA_W-1:1] == own_addr) && sh_q[0] && aa;

    // Transfer sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            sda_low_q <= 1'b0;
            si_q      <= 1'b0;
            status_q  <= CODE_NONE;
            last_q    <= 1'b0;
            end_q     <= 1'b0;
            arb_q     <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            if (arb_lost) arb_q <= 1'b1;
            if (stop_det && state_q != ST_HOLD) begin
                state_q   <= ST_IDLE;
                sda_low_q <= 1'b0;
                arb_q     <= 1'b0;
            end else if (start_det && state_q != ST_HOLD) begin
                state_q   <= ST_ADDR;
                cnt_q     <= '0;
                sda_low_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[DATA_W-2:0], sda_s};
                            cnt_q <= cnt_q + CNT_ONE;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            if (addr_hit) begin
                                state_q   <= ST_AACK;
                                sda_low_q <= 1'b1;
                            end else begin
                                state_q   <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            sda_low_q <= 1'b0;
                            si_q      <= 1'b1;
                            status_q  <= arb_q ? CODE_ARB_SLA_R : CODE_SLA_R;
                            arb_q     <= 1'b0;
                            end_q     <= 1'b0;
                            state_q   <= ST_HOLD;
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + CNT_ONE;
                        end else if (scl_fall) begin
                            if (cnt_q == CNT_FULL) begin
                                sda_low_q <= 1'b0;
                                state_q   <= ST_MACK;
                            end else begin
                                sh_q      <= {sh_q[DATA_W-2:0], 1'b0};
                                sda_low_q <= ~sh_q[DATA_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            ack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            si_q     <= 1'b1;
                            status_q <= !ack_q ? CODE_TX_NACK :
                                        (last_q ? CODE_LAST_ACK : CODE_TX_ACK);
                            end_q    <= !ack_q || last_q;
                            state_q  <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (si_clr) begin
                            si_q     <= 1'b0;
                            status_q <= CODE_NONE;
                            if (end_q) begin
                                state_q <= ST_IDLE;
                            end else begin
                                sh_q      <= tx_data;
                                sda_low_q <= ~tx_data[DATA_W-1];
                                last_q    <= ~aa;
                                cnt_q     <= '0;
                                state_q   <= ST_SEND;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Output mapping: stretching follows the waiting state.
    always_comb begin
        si       = si_q;
        status   = status_q;
        sda_low  = sda_low_q;
        scl_hold = (state_q == ST_HOLD);
    end

    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !si_q |-> (status_q == CODE_NONE));

    // R3
    si_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (si_q && !si_clr) |=> (si_q && $stable(status_q)));

    // R3
    scl_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        si_q |-> (state_q == ST_HOLD));

    // R4
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_q) |-> !$past(scl_s));

    // R4
    mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK) |-> !sda_low_q);

    // R5
    valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        si_q |-> (status_q == CODE_SLA_R || status_q == CODE_ARB_SLA_R ||
                  status_q == CODE_TX_ACK || status_q == CODE_TX_NACK ||
                  status_q == CODE_LAST_ACK));

endmodule

// File: rtl/i2c_slave_tx.sv
// Module: i2c_slave_tx (top)
// Slave transmitter engine: line synchronizer feeding the transfer core.
// Assumes: scl_i/sda_i are the resolved open-drain levels; clk runs at least
// several times faster than SCL so each SCL phase spans multiple clocks.
module i2c_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_hold_o,
    output logic              sda_low_o,
    input  logic [DATA_W-2:0] own_addr_i,
    input  logic              aa_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              si_clr_i,
    input  logic              arb_lost_i,
    output logic              si_o,
    output logic [7:0]        status_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_st_core #(.DATA_W(DATA_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr_i),
        .aa        (aa_i),
        .tx_data   (tx_data_i),
        .si_clr    (si_clr_i),
        .arb_lost  (arb_lost_i),
        .si        (si_o),
        .status    (status_o),
        .sda_low   (sda_low_o),
        .scl_hold  (scl_hold_o)
    );

endmodule

// File: tb/test_i2c_slave_tx.sv
// Bench for i2c_slave_tx: bus master model plus host model, table walk then directed cases.
module test_i2c_slave_tx;

    localparam int         PH  = 8;
    localparam logic [6:0] OWN = 7'h52;
    localparam int         NV  = 6;
    // {data[17:10], aa at release[9], master ack[8], expected status[7:0]}
    localparam logic [17:0] VEC [NV] = '{
        {8'hA5, 1'b1, 1'b1, 8'hB8},
        {8'h3C, 1'b1, 1'b0, 8'hC0},
        {8'h81, 1'b0, 1'b1, 8'hC8},
        {8'h5A, 1'b0, 1'b0, 8'hC0},
        {8'hF0, 1'b1, 1'b1, 8'hB8},
        {8'h0F, 1'b0, 1'b1, 8'hC8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_hold_o, sda_low_o, si_o;
    logic       aa = 1'b1, si_clr = 1'b0, arb_lost = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] status_o;
    int         n_chk = 0, n_fail = 0, cyc = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = m_scl & ~scl_hold_o;
    assign sda_bus = m_sda & ~sda_low_o;

    i2c_slave_tx i_i2c_slave_tx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_hold_o(scl_hold_o), .sda_low_o(sda_low_o), .own_addr_i(OWN),
        .aa_i(aa), .tx_data_i(tx_data), .si_clr_i(si_clr), .arb_lost_i(arb_lost),
        .si_o(si_o), .status_o(status_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b;
        wait_cyc(PH);
        m_scl = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wait_cyc(PH / 2);
        r = sda_bus;
        wait_cyc(PH / 2);
        m_scl = 1'b0;
        wait_cyc(PH);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_cyc(PH);
        m_scl = 1'b1; wait_cyc(PH);
        m_sda = 1'b0; wait_cyc(PH);
        m_scl = 1'b0; wait_cyc(PH);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_cyc(PH);
        m_scl = 1'b1; wait_cyc(PH);
        m_sda = 1'b1; wait_cyc(PH);
    endtask

    task automatic m_addr(input logic [6:0] a, input logic rw, output logic acked);
        logic r;
        for (int i = 6; i >= 0; i--) m_bit(a[i], r);
        m_bit(rw, r);
        m_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic m_read(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(~give_ack, r);
    endtask

    task automatic host_clear(input logic [7:0] d, input logic a);
        tx_data = d;
        aa      = a;
        si_clr  = 1'b1;
        @(negedge clk);
        si_clr  = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        logic       ack;
        logic [7:0] got;
        wait_cyc(3);
        chk("R1 reset status", status_o, 8'hF8);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1 si", {7'd0, si_o}, 8'd0);
        chk("R1 status", status_o, 8'hF8);
        chk("R1 sda_low", {7'd0, sda_low_o}, 8'd0);
        chk("R1 scl_hold", {7'd0, scl_hold_o}, 8'd0);

        // Table walk: one addressed read transaction per vector.
        for (int v = 0; v < NV; v++) begin
            m_start();
            m_addr(OWN, 1'b1, ack);
            chk("R2 address ack", {7'd0, ack}, 8'd1);
            chk("R2 si", {7'd0, si_o}, 8'd1);
            chk("R2 status", status_o, 8'hA8);
            chk("R3 scl held", {7'd0, scl_hold_o}, 8'd1);
            host_clear(VEC[v][17:10], VEC[v][9]);
            chk("R3 si cleared", {7'd0, si_o}, 8'd0);
            chk("R3 status idle", status_o, 8'hF8);
            chk("R3 scl released", {7'd0, scl_hold_o}, 8'd0);
            m_read(VEC[v][8], got);
            chk("R4 byte", got, VEC[v][17:10]);
            chk("R5 R6 status", status_o, VEC[v][7:0]);
            if (VEC[v][7:0] == 8'hB8) begin
                host_clear(~VEC[v][17:10], 1'b0);
                m_read(1'b1, got);
                chk("R6 last byte", got, ~VEC[v][17:10]);
                chk("R6 status C8", status_o, 8'hC8);
            end
            host_clear(8'h00, 1'b1);
            m_read(1'b1, got);
            chk("R5 R6 detached ones", got, 8'hFF);
            chk("R5 R6 no si", {7'd0, si_o}, 8'd0);
            m_stop();
        end

        // R7: recognition off, then back on.
        aa = 1'b0;
        m_start();
        m_addr(OWN, 1'b1, ack);
        chk("R7 no ack with aa low", {7'd0, ack}, 8'd0);
        chk("R7 no si", {7'd0, si_o}, 8'd0);
        chk("R7 status", status_o, 8'hF8);
        m_stop();
        aa = 1'b1;
        m_start();
        m_addr(OWN, 1'b1, ack);
        chk("R7 ack restored", {7'd0, ack}, 8'd1);
        chk("R7 status", status_o, 8'hA8);
        host_clear(8'h69, 1'b1);
        m_read(1'b0, got);
        chk("R7 byte", got, 8'h69);
        chk("R5 nack status", status_o, 8'hC0);
        host_clear(8'h00, 1'b1);
        m_stop();

        // R8: mismatched address and write direction.
        m_start();
        m_addr(OWN ^ 7'h01, 1'b1, ack);
        chk("R8 other address", {7'd0, ack}, 8'd0);
        chk("R8 no si", {7'd0, si_o}, 8'd0);
        m_stop();
        m_start();
        m_addr(OWN, 1'b0, ack);
        chk("R8 write direction", {7'd0, ack}, 8'd0);
        chk("R8 no si", {7'd0, si_o}, 8'd0);
        m_stop();

        // R9: addressed right after losing arbitration.
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
        m_start();
        m_addr(OWN, 1'b1, ack);
        chk("R9 ack", {7'd0, ack}, 8'd1);
        chk("R9 status B0", status_o, 8'hB0);
        host_clear(8'hC3, 1'b1);
        m_read(1'b0, got);
        chk("R9 byte", got, 8'hC3);
        host_clear(8'h00, 1'b1);
        m_stop();

        // R10: STOP in the middle of a byte of all ones.
        m_start();
        m_addr(OWN, 1'b1, ack);
        chk("R10 setup status", status_o, 8'hA8);
        host_clear(8'hFF, 1'b1);
        for (int i = 0; i < 3; i++) m_bit(1'b1, ack);
        m_stop();
        wait_cyc(4);
        chk("R10 sda released", {7'd0, sda_low_o}, 8'd0);
        m_scl = 1'b0;
        wait_cyc(PH);
        m_read(1'b1, got);
        chk("R10 ones after stop", got, 8'hFF);
        chk("R10 no si", {7'd0, si_o}, 8'd0);
        m_stop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule